// File: doc/BRIEF.md
# Stereo PCM Serializer for Audio DACs

This block turns pairs of 16-bit left and right samples into the four-wire serial stream that an external audio DAC expects: an oversampling master clock, a bit clock, a left/right word clock and one serial data line. All timing is derived from the system clock, qualified by a clock enable `clk_en`. Each asserted enable cycle is one half period of the master clock. A bit clock period is always eight master clock periods.

A 14-bit format register sets the behaviour while the block runs. It selects the justification (I2S, where data trails the word clock edge by one bit, or normal, where data starts on the edge), the bit order, which bit clock edge launches data, which word clock level means left, and the frame size. The frame size couples the master clock ratio to the bit clock ratio: either 256·Fs master with 32·Fs bit clock, or 384·Fs master with 48·Fs bit clock. A write to the register is held back until the next left-channel frame starts, so a frame never mixes two formats. Samples arrive through a valid/ready handshake into a one-pair holding slot. The slot is drained at each left frame start. When no new pair has arrived, the previous pair is sent again.

Top module: `pcm_dac_serializer`

## Requirements
- R1: The format register resets to 0x2103. A one-cycle `cfg_we` pulse stores all 14 bits of `cfg_wdata`, and `cfg_q` reads them back on the following cycle.
- R2: Format bit 1 = 0 gives 32 bit clock periods per word clock period and 256 master clock periods per frame. Bit 1 = 1 gives 48 and 384. In both cases eight master clock rising edges fall between successive capture edges of the bit clock.
- R3: Format bit 2 = 0 sends each channel's 16 sample bits MSB first. Bit 2 = 1 sends them LSB first.
- R4: Data and word clock change only on the launch edge of the bit clock: the falling edge when format bit 3 = 0, the rising edge when bit 3 = 1. They are stable across the opposite (capture) edge. During reset all four outputs are 0.
- R5: Format bit 5 = 0 drives the word clock high for the left channel and low for the right channel. Bit 5 = 1 inverts this.
- R6: Each frame carries the left channel in its first half and the right channel in its second half. Each half is 16 or 24 bit slots. The 16 sample bits come first, and any remaining slots carry 0.
- R7: Format bit 0 = 1 (normal) places the first data bit of a channel in the same slot as the word clock change. Bit 0 = 0 (I2S) changes the word clock one slot before the first data bit.
- R8: Format bits 4 and 12 and the other unnamed bits are stored and read back but have no effect on the serial outputs.
- R9: `s_ready` is high while the holding slot is empty. A pair is taken when `s_valid` and `s_ready` are both high. `s_ready` is then low on the next cycle and stays low until the next left frame start, when the held pair moves to the serializer.
- R10: When the holding slot is empty at a left frame start, the previous pair is serialized again.
- R11: A format write made partway through a frame leaves the rest of that frame unchanged. The new format applies from the next left frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Half-period tick of the master clock |
| cfg_we | input | 1 | Format register write strobe |
| cfg_wdata | input | 14 | Format register write value |
| cfg_q | output | 14 | Stored format register value |
| s_valid | input | 1 | Sample pair offered |
| s_left | input | 16 | Left channel sample |
| s_right | input | 16 | Right channel sample |
| s_ready | output | 1 | Holding slot empty, pair will be taken |
| mclk_o | output | 1 | Oversampling master clock to DAC |
| bck_o | output | 1 | Bit clock to DAC |
| lrck_o | output | 1 | Left/right word clock to DAC |
| sdata_o | output | 1 | Serial sample data to DAC |

## Verification
The hardest case to reach from the ports is a format write that lands in the middle of a frame. The outputs show nothing of the deferred format until the left boundary. To reach it, the stimulus locks onto the word clock, counts capture edges, and issues the write on a chosen bit of a running frame. It then checks that the frame ends in the old bit order and that later frames use the new order. Repeated pairs are reached by capturing two frames in a row without offering a new sample.

// File: rtl/pcm_ser_pkg.sv
package pcm_ser_pkg;

  localparam int CFG_W = 14;
  localparam logic [CFG_W-1:0] CFG_RESET = 14'h2103;

  // bit positions that carry behaviour
  localparam int FB_NORMAL = 0;
  localparam int FB_LONG   = 1;
  localparam int FB_LSB    = 2;
  localparam int FB_RISE   = 3;
  localparam int FB_LLOW   = 5;

  typedef struct packed {
    logic normal;      // data on the word clock edge instead of one slot after
    logic long_frame;  // 48 slots, 384x master clock
    logic lsb_first;
    logic rise_launch; // data launched on the rising bit clock edge
    logic left_low;    // word clock low marks the left channel
  } fmt_t;

  function automatic fmt_t fmt_decode(input logic [CFG_W-1:0] raw);
    fmt_t f;
    f.normal      = raw[FB_NORMAL];
    f.long_frame  = raw[FB_LONG];
    f.lsb_first   = raw[FB_LSB];
    f.rise_launch = raw[FB_RISE];
    f.left_low    = raw[FB_LLOW];
    return f;
  endfunction

endpackage

// File: rtl/pcm_cfg_reg.sv
module pcm_cfg_reg
  import pcm_ser_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             frame_start,
  output logic [CFG_W-1:0] cfg_q,
  output fmt_t             act_fmt
);

  logic [CFG_W-1:0] stored;

  always_ff @(posedge clk) begin
    if (rst) stored <= CFG_RESET;
    else if (wr_en) stored <= wr_data;
  end

  // the format in use only moves at a left frame boundary
  always_ff @(posedge clk) begin
    if (rst) act_fmt <= fmt_decode(CFG_RESET);
    else if (frame_start) act_fmt <= fmt_decode(stored);
  end

  assign cfg_q = stored;

  AST_FMT_HELD: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(act_fmt)); // R11

endmodule

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer #(
  parameter int BCK_DIV    = 8,
  parameter int SLOT_SHORT = 16,
  parameter int SLOT_LONG  = 24,
  localparam int SBW = $clog2(2 * BCK_DIV),
  localparam int SLW = $clog2(2 * SLOT_LONG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clk_en,
  input  logic           long_frame,
  output logic [SBW-1:0] sub,
  output logic [SLW-1:0] slot,
  output logic           frame_start
);

  localparam logic [SBW-1:0] SUB_LAST = SBW'(2 * BCK_DIV - 1);

  logic [SLW-1:0] half_n, last_slot;
  logic           sub_wrap;

  always_comb begin
    half_n    = long_frame ? SLW'(SLOT_LONG) : SLW'(SLOT_SHORT);
    last_slot = half_n + half_n - SLW'(1);
    sub_wrap  = clk_en && (sub == SUB_LAST);
    frame_start = sub_wrap && (slot == last_slot);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sub  <= '0;
      slot <= '0;
    end else if (clk_en) begin
      sub <= (sub == SUB_LAST) ? '0 : sub + SBW'(1);
      if (sub_wrap) slot <= (slot == last_slot) ? '0 : slot + SLW'(1);
    end
  end

endmodule

// File: rtl/pcm_sample_buf.sv
module pcm_sample_buf #(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s_valid,
  input  logic [SW-1:0] s_left,
  input  logic [SW-1:0] s_right,
  output logic          s_ready,
  input  logic          frame_start,
  output logic [SW-1:0] cur_l,
  output logic [SW-1:0] cur_r
);

  logic          hold_full;
  logic [SW-1:0] hold_l, hold_r;
  logic          take;

  assign s_ready = !hold_full;
  assign take    = s_valid && !hold_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full <= 1'b0;
      hold_l    <= '0;
      hold_r    <= '0;
      cur_l     <= '0;
      cur_r     <= '0;
    end else begin
      if (frame_start && hold_full) begin
        cur_l <= hold_l;
        cur_r <= hold_r;
      end
      if (take) begin
        hold_l    <= s_left;
        hold_r    <= s_right;
        hold_full <= 1'b1;
      end else if (frame_start) begin
        hold_full <= 1'b0;
      end
    end
  end

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> !s_ready); // R9

  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
    (hold_full && !frame_start) |=> ($stable(hold_l) && $stable(hold_r))); // R9

  AST_PAIR_REPEAT: assert property (@(posedge clk) disable iff (rst)
    (frame_start && !hold_full) |=> ($stable(cur_l) && $stable(cur_r))); // R10

endmodule

// File: rtl/pcm_out_stage.sv
module pcm_out_stage
  import pcm_ser_pkg::*;
#(
  parameter int SW         = 16,
  parameter int BCK_DIV    = 8,
  parameter int SLOT_SHORT = 16,
  parameter int SLOT_LONG  = 24,
  localparam int SBW  = $clog2(2 * BCK_DIV),
  localparam int SLW  = $clog2(2 * SLOT_LONG),
  localparam int IDXW = $clog2(SW)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clk_en,
  input  fmt_t           fmt,
  input  logic [SBW-1:0] sub,
  input  logic [SLW-1:0] slot,
  input  logic [SW-1:0]  cur_l,
  input  logic [SW-1:0]  cur_r,
  output logic           mclk_o,
  output logic           bck_o,
  output logic           lrck_o,
  output logic           sdata_o
);

  logic [SLW-1:0]  half_n, last_slot, nxt, pos;
  logic            left_now, left_lr, bit_v, bck_v;
  logic [SW-1:0]   smp;
  logic [IDXW-1:0] idx;

  always_comb begin
    half_n    = fmt.long_frame ? SLW'(SLOT_LONG) : SLW'(SLOT_SHORT);
    last_slot = half_n + half_n - SLW'(1);
    nxt       = (slot == last_slot) ? '0 : slot + SLW'(1);
    left_now  = slot < half_n;
    // I2S moves the word clock one slot early
    left_lr   = fmt.normal ? left_now : (nxt < half_n);
    pos       = left_now ? slot : slot - half_n;
    smp       = left_now ? cur_l : cur_r;
    idx       = fmt.lsb_first ? pos[IDXW-1:0] : (IDXW'(SW - 1) - pos[IDXW-1:0]);
    bit_v     = (pos < SLW'(SW)) ? smp[idx] : 1'b0;
    bck_v     = (sub < SBW'(BCK_DIV)) ? fmt.rise_launch : !fmt.rise_launch;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mclk_o  <= 1'b0;
      bck_o   <= 1'b0;
      lrck_o  <= 1'b0;
      sdata_o <= 1'b0;
    end else if (clk_en) begin
      mclk_o  <= sub[0];
      bck_o   <= bck_v;
      lrck_o  <= left_lr ^ fmt.left_low;
      sdata_o <= bit_v;
    end
  end

  AST_BCK_EDGES: assert property (@(posedge clk) disable iff (rst)
    (clk_en && sub != '0 && sub != SBW'(BCK_DIV)) |=> $stable(bck_o)); // R4

endmodule

// File: rtl/pcm_dac_serializer.sv
module pcm_dac_serializer
  import pcm_ser_pkg::*;
#(
  parameter int SW         = 16,
  parameter int BCK_DIV    = 8,
  parameter int SLOT_SHORT = 16,
  parameter int SLOT_LONG  = 24,
  localparam int SBW = $clog2(2 * BCK_DIV),
  localparam int SLW = $clog2(2 * SLOT_LONG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_en,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_q,
  input  logic             s_valid,
  input  logic [SW-1:0]    s_left,
  input  logic [SW-1:0]    s_right,
  output logic             s_ready,
  output logic             mclk_o,
  output logic             bck_o,
  output logic             lrck_o,
  output logic             sdata_o
);

  fmt_t           act_fmt;
  logic [SBW-1:0] sub;
  logic [SLW-1:0] slot;
  logic           frame_start;
  logic [SW-1:0]  cur_l, cur_r;

  pcm_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_data(cfg_wdata),
    .frame_start(frame_start), .cfg_q(cfg_q), .act_fmt(act_fmt)
  );

  pcm_frame_timer #(.BCK_DIV(BCK_DIV), .SLOT_SHORT(SLOT_SHORT), .SLOT_LONG(SLOT_LONG)) u_timer (
    .clk(clk), .rst(rst), .clk_en(clk_en), .long_frame(act_fmt.long_frame),
    .sub(sub), .slot(slot), .frame_start(frame_start)
  );

  pcm_sample_buf #(.SW(SW)) u_buf (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_left(s_left), .s_right(s_right),
    .s_ready(s_ready), .frame_start(frame_start), .cur_l(cur_l), .cur_r(cur_r)
  );

  pcm_out_stage #(.SW(SW), .BCK_DIV(BCK_DIV), .SLOT_SHORT(SLOT_SHORT), .SLOT_LONG(SLOT_LONG)) u_out (
    .clk(clk), .rst(rst), .clk_en(clk_en), .fmt(act_fmt), .sub(sub), .slot(slot),
    .cur_l(cur_l), .cur_r(cur_r),
    .mclk_o(mclk_o), .bck_o(bck_o), .lrck_o(lrck_o), .sdata_o(sdata_o)
  );

endmodule

// File: tb/pcm_dac_serializer_test.sv
module pcm_dac_serializer_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clk_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [13:0] cfg_wdata = '0;
  logic [13:0] cfg_q;
  logic        s_valid = 1'b0;
  logic [15:0] s_left = '0, s_right = '0;
  logic        s_ready, mclk_o, bck_o, lrck_o, sdata_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  pcm_dac_serializer uut (
    .clk(clk), .rst(rst), .clk_en(clk_en), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_q(cfg_q), .s_valid(s_valid), .s_left(s_left), .s_right(s_right),
    .s_ready(s_ready), .mclk_o(mclk_o), .bck_o(bck_o), .lrck_o(lrck_o), .sdata_o(sdata_o)
  );

  // {format, left, right}
  localparam logic [45:0] VEC [8] = '{
    {14'h2103, 16'hA5C3, 16'h1234},
    {14'h0000, 16'h8001, 16'h7F3C},
    {14'h0004, 16'hC0DE, 16'h0F0F},
    {14'h0008, 16'h5A5A, 16'hFFFE},
    {14'h0021, 16'h9E37, 16'h4000},
    {14'h002E, 16'h0001, 16'hB00C},
    {14'h1013, 16'h6D2B, 16'hE4A1},
    {14'h0003, 16'h6D2B, 16'hE4A1}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [13:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(cfg_q == v, "R1 format readback", 64'(cfg_q), 64'(v));
  endtask

  task automatic push(input logic [15:0] l, input logic [15:0] r);
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    s_valid = 1'b1;
    s_left = l;
    s_right = r;
    @(negedge clk);
    s_valid = 1'b0;
    chk(s_ready == 1'b0, "R9 ready low after accept", 64'(s_ready), 64'd0);
  endtask

  // Lock onto a left frame, capture N+1 bits and compare with the format rules.
  task automatic run_frame(input logic [13:0] c, input logic [15:0] l, input logic [15:0] r,
                           input int wr_at, input logic [13:0] wcfg, input string tag);
    int n    = c[1] ? 48 : 32;
    int half = n / 2;
    bit rise = c[3];
    bit llvl = !c[5];
    bit i2s  = !c[0];
    logic [48:0] exp_d = '0, exp_lr = '0, got_d = '0, got_lr = '0, mask;
    int k = -1;
    bit armed = 1'b0, plr_cap = llvl, pb, plr, pd, pm, we_clr = 1'b0;
    int bad_edge = 0, mrise = 0;
    for (int i = 0; i < n; i++) begin
      bit li = i < half;
      int p = li ? i : i - half;
      logic [15:0] s = li ? l : r;
      bit lr_left = i2s ? (((i + 1) % n) < half) : li;
      exp_d[i]  = (p < 16) ? s[c[2] ? p : 15 - p] : 1'b0;
      exp_lr[i] = lr_left ? llvl : !llvl;
    end
    exp_lr[n] = exp_lr[0];
    mask = (49'd1 << n) - 49'd1;
    @(negedge clk);
    pb = bck_o; plr = lrck_o; pd = sdata_o; pm = mclk_o;
    while (k < n) begin
      bit cap, launch;
      @(negedge clk);
      if (we_clr) begin cfg_we = 1'b0; we_clr = 1'b0; end
      cap    = (bck_o != pb) && (bck_o == !rise);
      launch = (bck_o != pb) && (bck_o == rise);
      if (k >= 0 && ((sdata_o != pd) || (lrck_o != plr)) && !launch) bad_edge++;
      if (k >= 0 && k < n - 1 && mclk_o && !pm) mrise++;
      if (cap) begin
        if (k < 0) begin
          bit trans = (lrck_o == llvl) && (plr_cap != llvl);
          if ((!i2s && trans) || (i2s && armed)) k = 0;
          armed = i2s && trans;
          plr_cap = lrck_o;
        end else begin
          k++;
        end
        if (k >= 0) begin
          got_d[k]  = sdata_o;
          got_lr[k] = lrck_o;
          if (k == wr_at) begin
            cfg_we = 1'b1;
            cfg_wdata = wcfg;
            we_clr = 1'b1;
          end
        end
      end
      pb = bck_o; plr = lrck_o; pd = sdata_o; pm = mclk_o;
    end
    if (we_clr) begin @(negedge clk); cfg_we = 1'b0; end
    chk((got_d & mask) == (exp_d & mask), {tag, " R3 R6 R7 R8 R11 data bits"},
        64'(got_d & mask), 64'(exp_d & mask));
    chk((got_lr & {mask, 1'b1}) == (exp_lr & {mask, 1'b1}), {tag, " R5 R7 R2 word clock"},
        64'(got_lr), 64'(exp_lr));
    chk(bad_edge == 0, {tag, " R4 change off launch edge"}, 64'(bad_edge), 64'd0);
    chk(mrise == (n - 1) * 8, {tag, " R2 master clock count"}, 64'(mrise), 64'((n - 1) * 8));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(cfg_q == 14'h2103, "R1 reset format", 64'(cfg_q), 64'h2103);
    chk(s_ready == 1'b1, "R9 ready after reset", 64'(s_ready), 64'd1);
    chk({mclk_o, bck_o, lrck_o, sdata_o} == 4'b0, "R4 outputs in reset",
        64'({mclk_o, bck_o, lrck_o, sdata_o}), 64'd0);
    rst = 1'b0;
    clk_en = 1'b1;

    for (int v = 0; v < 8; v++) begin
      logic [13:0] c = VEC[v][45:32];
      logic [15:0] l = VEC[v][31:16];
      logic [15:0] r = VEC[v][15:0];
      write_cfg(c);
      push(l, r);
      repeat (1700) @(negedge clk);
      run_frame(c, l, r, -1, 14'h0, $sformatf("vec%0d", v));
      run_frame(c, l, r, -1, 14'h0, $sformatf("vec%0d R10 repeat", v));
    end

    // R11: format write in the middle of a running frame
    write_cfg(14'h0001);
    push(16'hF00D, 16'h1357);
    repeat (1700) @(negedge clk);
    run_frame(14'h0001, 16'hF00D, 16'h1357, 5, 14'h0005, "R11 old frame");
    chk(cfg_q == 14'h0005, "R1 R11 stored after mid write", 64'(cfg_q), 64'h0005);
    run_frame(14'h0005, 16'hF00D, 16'h1357, -1, 14'h0, "R11 new frame");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule